// File: doc/BRIEF.md
# Data-Space Address Decoder and RAM

This block maps one 8-bit data address bus onto on-chip RAM, I/O port registers, peripheral holding registers and a 16-byte register bank. A caller presents an address along with a read strobe, a write strobe and write data. Read data comes back registered. For each access the block raises one select strobe that names the peripheral group being touched: port, timer, serial shift, or control/status.

The parameter `RAM_BYTES` sets the RAM size to either 48 or 112 bytes. RAM starts at address 0. Addresses from the end of RAM up to 0x7F form a gap that reads back as all ones. The register bank sits at 0xF0–0xFF. Three of its bytes also serve as the X pointer (0xFC), the stack pointer (0xFD) and the B pointer (0xFE). The block drives these three continuously so that address-generation logic can use them. Port input pins are visible only as read-only locations.

Top module: `data_space_map`

## Requirements
- R1: While `rst_ni` is low, every port, timer, shift and control/status register and `rdata_o` are cleared to 0x00. RAM and the register bank are not reset.
- R2: Addresses 0x00 up to `RAM_BYTES`-1 are read/write RAM bytes. The default is 48, giving 0x00–0x2F.
- R3: Addresses from `RAM_BYTES` to 0x7F read as 0xFF. Writes to them change no storage.
- R4: The following addresses read as 0x00 and ignore writes: 0x80–0xCF, 0xD3, 0xD8–0xDB, 0xDD–0xDF and 0xE0–0xE8.
- R5: `rdata_o` takes the addressed value on the clock edge where `rd_i` is high. It holds its value while `rd_i` is low.
- R6: Writable port registers, each readable back and driven on its output: 0xD0 is port L data, 0xD1 is port L config, 0xD4 is port G data, 0xD5 is port G config, and 0xDC is port D data.
- R7: 0xD2, 0xD6 and 0xD7 return `pins_l_i`, `pins_g_i` and `pins_i_i`. Writes to these addresses change no register.
- R8: Peripheral registers: 0xE9 is shift, 0xEA/0xEB are timer low/high (`timer_o` = {0xEB, 0xEA}), 0xEC/0xED are reload low/high, 0xEE is control and 0xEF is status. Each is written and read at its address.
- R9: 0xF0–0xFF is a 16-byte read/write bank. `x_o`, `sp_o` and `b_o` always show bytes 0xFC, 0xFD and 0xFE.
- R10: When `rd_i` or `wr_i` is high, exactly one select strobe is raised for a mapped peripheral address. `sel_port_o` covers 0xD0–0xD2, 0xD4–0xD7 and 0xDC. `sel_shift_o` covers 0xE9. `sel_timer_o` covers 0xEA–0xED. `sel_ctrl_o` covers 0xEE–0xEF. All strobes are low otherwise.
- R11: A read and a write to the same address in the same cycle returns the value stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Data address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pins_l_i | input | 8 | Port L input pins |
| pins_g_i | input | 8 | Port G input pins |
| pins_i_i | input | 8 | Port I input pins |
| port_l_dat_o | output | 8 | Port L data register |
| port_l_cfg_o | output | 8 | Port L config register |
| port_g_dat_o | output | 8 | Port G data register |
| port_g_cfg_o | output | 8 | Port G config register |
| port_d_dat_o | output | 8 | Port D data register |
| shift_o | output | 8 | Serial shift register |
| timer_o | output | 16 | Timer value |
| reload_o | output | 16 | Timer reload value |
| ctrl_o | output | 8 | Control register |
| status_o | output | 8 | Status word |
| x_o | output | 8 | X pointer (bank byte 0xFC) |
| sp_o | output | 8 | Stack pointer (bank byte 0xFD) |
| b_o | output | 8 | B pointer (bank byte 0xFE) |
| sel_port_o | output | 1 | Port group select |
| sel_timer_o | output | 1 | Timer group select |
| sel_shift_o | output | 1 | Shift register select |
| sel_ctrl_o | output | 1 | Control/status select |

## Verification
A decode fault that steers a write to the wrong target shows up as corrupted state. It appears on the register outputs on the clock edge after the write. For RAM and the bank it appears one cycle after the next read of the victim address. That is why the bench writes to the gap and to read-only locations, then reads back the low RAM bytes and the port outputs those writes could alias. A wrong read-mux selection shows on `rdata_o` exactly one edge after the read strobe. Strobe faults are combinational and are visible in the same cycle as the access.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int NREG   = 12;
  localparam int PIDX_W = 4;

  // peripheral register slots
  localparam int P_L_DAT  = 0;
  localparam int P_L_CFG  = 1;
  localparam int P_G_DAT  = 2;
  localparam int P_G_CFG  = 3;
  localparam int P_D_DAT  = 4;
  localparam int P_SHIFT  = 5;
  localparam int P_TMR_LO = 6;
  localparam int P_TMR_HI = 7;
  localparam int P_RLD_LO = 8;
  localparam int P_RLD_HI = 9;
  localparam int P_CTRL   = 10;
  localparam int P_STAT   = 11;

  typedef enum logic [2:0] {
    RG_NONE, RG_RAM, RG_GAP, RG_PIN_L, RG_PIN_G, RG_PIN_I, RG_PREG, RG_RFILE
  } region_e;

  typedef enum logic [2:0] {
    GRP_NONE, GRP_PORT, GRP_TIMER, GRP_SHIFT, GRP_CTRL
  } grp_e;

  typedef struct packed {
    region_e           region;
    grp_e              grp;
    logic [PIDX_W-1:0] pidx;
  } dec_t;

  function automatic dec_t decode(input logic [7:0] a, input int ram_bytes);
    dec_t d;
    d.region = RG_NONE;
    d.grp    = GRP_NONE;
    d.pidx   = '0;
    if (int'(a) < ram_bytes) begin
      d.region = RG_RAM;
    end else if (!a[7]) begin
      d.region = RG_GAP;
    end else if (a[7:4] == 4'hF) begin
      d.region = RG_RFILE;
    end else begin
      case (a)
        8'hD0: begin d.region = RG_PREG;  d.grp = GRP_PORT;  d.pidx = PIDX_W'(P_L_DAT);  end
        8'hD1: begin d.region = RG_PREG;  d.grp = GRP_PORT;  d.pidx = PIDX_W'(P_L_CFG);  end
        8'hD2: begin d.region = RG_PIN_L; d.grp = GRP_PORT;  end
        8'hD4: begin d.region = RG_PREG;  d.grp = GRP_PORT;  d.pidx = PIDX_W'(P_G_DAT);  end
        8'hD5: begin d.region = RG_PREG;  d.grp = GRP_PORT;  d.pidx = PIDX_W'(P_G_CFG);  end
        8'hD6: begin d.region = RG_PIN_G; d.grp = GRP_PORT;  end
        8'hD7: begin d.region = RG_PIN_I; d.grp = GRP_PORT;  end
        8'hDC: begin d.region = RG_PREG;  d.grp = GRP_PORT;  d.pidx = PIDX_W'(P_D_DAT);  end
        8'hE9: begin d.region = RG_PREG;  d.grp = GRP_SHIFT; d.pidx = PIDX_W'(P_SHIFT);  end
        8'hEA: begin d.region = RG_PREG;  d.grp = GRP_TIMER; d.pidx = PIDX_W'(P_TMR_LO); end
        8'hEB: begin d.region = RG_PREG;  d.grp = GRP_TIMER; d.pidx = PIDX_W'(P_TMR_HI); end
        8'hEC: begin d.region = RG_PREG;  d.grp = GRP_TIMER; d.pidx = PIDX_W'(P_RLD_LO); end
        8'hED: begin d.region = RG_PREG;  d.grp = GRP_TIMER; d.pidx = PIDX_W'(P_RLD_HI); end
        8'hEE: begin d.region = RG_PREG;  d.grp = GRP_CTRL;  d.pidx = PIDX_W'(P_CTRL);   end
        8'hEF: begin d.region = RG_PREG;  d.grp = GRP_CTRL;  d.pidx = PIDX_W'(P_STAT);   end
        default: ;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/dsm_decode.sv
module dsm_decode
  import dsm_pkg::*;
#(
  parameter int RAM_BYTES = 48
) (
  input  logic [7:0] addr_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output dec_t       dec_o,
  output logic       sel_port_o,
  output logic       sel_timer_o,
  output logic       sel_shift_o,
  output logic       sel_ctrl_o
);
  logic acc;

  assign dec_o = decode(addr_i, RAM_BYTES);
  assign acc   = rd_i | wr_i;

  assign sel_port_o  = acc && (dec_o.grp == GRP_PORT);
  assign sel_timer_o = acc && (dec_o.grp == GRP_TIMER);
  assign sel_shift_o = acc && (dec_o.grp == GRP_SHIFT);
  assign sel_ctrl_o  = acc && (dec_o.grp == GRP_CTRL);
endmodule

// File: rtl/dsm_ram.sv
module dsm_ram #(
  parameter int DEPTH = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  // contents intentionally not reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/dsm_periph.sv
module dsm_periph
  import dsm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [PIDX_W-1:0]     idx_i,
  input  logic [7:0]            wdata_i,
  output logic [NREG-1:0][7:0]  q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q_o[g] <= '0;
      else if (we_i && (idx_i == PIDX_W'(g)))     q_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/dsm_rfile.sv
module dsm_rfile #(
  parameter int X_IDX  = 12,
  parameter int SP_IDX = 13,
  parameter int B_IDX  = 14
) (
  input  logic       clk_i,
  input  logic       we_i,
  input  logic [3:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] x_o,
  output logic [7:0] sp_o,
  output logic [7:0] b_o
);
  logic [7:0] bank [16];

  always_ff @(posedge clk_i) begin
    if (we_i) bank[idx_i] <= wdata_i;
  end

  assign rdata_o = bank[idx_i];
  assign x_o     = bank[X_IDX];
  assign sp_o    = bank[SP_IDX];
  assign b_o     = bank[B_IDX];
endmodule

// File: rtl/data_space_map.sv
module data_space_map
  import dsm_pkg::*;
#(
  parameter int RAM_BYTES = 48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  pins_l_i,
  input  logic [7:0]  pins_g_i,
  input  logic [7:0]  pins_i_i,
  output logic [7:0]  port_l_dat_o,
  output logic [7:0]  port_l_cfg_o,
  output logic [7:0]  port_g_dat_o,
  output logic [7:0]  port_g_cfg_o,
  output logic [7:0]  port_d_dat_o,
  output logic [7:0]  shift_o,
  output logic [15:0] timer_o,
  output logic [15:0] reload_o,
  output logic [7:0]  ctrl_o,
  output logic [7:0]  status_o,
  output logic [7:0]  x_o,
  output logic [7:0]  sp_o,
  output logic [7:0]  b_o,
  output logic        sel_port_o,
  output logic        sel_timer_o,
  output logic        sel_shift_o,
  output logic        sel_ctrl_o
);
  localparam int AW = $clog2(RAM_BYTES);

  dec_t                dec;
  logic [7:0]          ram_rd, rf_rd, rd_mux;
  logic [NREG-1:0][7:0] preg;

  dsm_decode #(.RAM_BYTES(RAM_BYTES)) u_dec (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .dec_o       (dec),
    .sel_port_o  (sel_port_o),
    .sel_timer_o (sel_timer_o),
    .sel_shift_o (sel_shift_o),
    .sel_ctrl_o  (sel_ctrl_o)
  );

  dsm_ram #(.DEPTH(RAM_BYTES)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_i && (dec.region == RG_RAM)),
    .addr_i  (addr_i[AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  dsm_periph u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && (dec.region == RG_PREG)),
    .idx_i   (dec.pidx),
    .wdata_i (wdata_i),
    .q_o     (preg)
  );

  dsm_rfile #(.X_IDX(12), .SP_IDX(13), .B_IDX(14)) u_rf (
    .clk_i   (clk_i),
    .we_i    (wr_i && (dec.region == RG_RFILE)),
    .idx_i   (addr_i[3:0]),
    .wdata_i (wdata_i),
    .rdata_o (rf_rd),
    .x_o     (x_o),
    .sp_o    (sp_o),
    .b_o     (b_o)
  );

  always_comb begin
    unique case (dec.region)
      RG_RAM:   rd_mux = ram_rd;
      RG_GAP:   rd_mux = 8'hFF;
      RG_PIN_L: rd_mux = pins_l_i;
      RG_PIN_G: rd_mux = pins_g_i;
      RG_PIN_I: rd_mux = pins_i_i;
      RG_PREG:  rd_mux = preg[dec.pidx];
      RG_RFILE: rd_mux = rf_rd;
      default:  rd_mux = 8'h00;
    endcase
  end

  // read samples pre-write contents on a same-cycle read/write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign port_l_dat_o = preg[P_L_DAT];
  assign port_l_cfg_o = preg[P_L_CFG];
  assign port_g_dat_o = preg[P_G_DAT];
  assign port_g_cfg_o = preg[P_G_CFG];
  assign port_d_dat_o = preg[P_D_DAT];
  assign shift_o      = preg[P_SHIFT];
  assign timer_o      = {preg[P_TMR_HI], preg[P_TMR_LO]};
  assign reload_o     = {preg[P_RLD_HI], preg[P_RLD_LO]};
  assign ctrl_o       = preg[P_CTRL];
  assign status_o     = preg[P_STAT];
endmodule

// File: rtl/dsm_chk.sv
module dsm_chk #(
  parameter int RAM_BYTES = 48
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] pins_g_i,
  input logic [7:0] port_l_dat_o,
  input logic [7:0] port_l_cfg_o,
  input logic [7:0] ctrl_o,
  input logic [7:0] x_o,
  input logic       sel_port_o,
  input logic       sel_timer_o,
  input logic       sel_shift_o,
  input logic       sel_ctrl_o
);
  // R3
  gap_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && int'(addr_i) >= RAM_BYTES && !addr_i[7]) |=> rdata_o == 8'hFF);

  // R4
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[7] && addr_i < 8'hD0) |=> rdata_o == 8'h00);

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R7
  pin_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 8'hD6) |=> rdata_o == $past(pins_g_i));

  // R7
  pin_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'hD2) |=> $stable(port_l_dat_o) && $stable(port_l_cfg_o));

  // R8
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'hEE) |=> ctrl_o == $past(wdata_i));

  // R9
  x_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'hFC) |=> x_o == $past(wdata_i));

  // R10
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_port_o, sel_timer_o, sel_shift_o, sel_ctrl_o}));

  // R10
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> {sel_port_o, sel_timer_o, sel_shift_o, sel_ctrl_o} == 4'b0);
endmodule

bind data_space_map dsm_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .pins_g_i     (pins_g_i),
  .port_l_dat_o (port_l_dat_o),
  .port_l_cfg_o (port_l_cfg_o),
  .ctrl_o       (ctrl_o),
  .x_o          (x_o),
  .sel_port_o   (sel_port_o),
  .sel_timer_o  (sel_timer_o),
  .sel_shift_o  (sel_shift_o),
  .sel_ctrl_o   (sel_ctrl_o)
);

// File: tb/sim_data_space_map.sv
module sim_data_space_map;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  pl = 8'hA5, pg = 8'h3C, pi = 8'h96;
  logic [7:0]  rdata, pld, plc, pgd, pgc, pdd, shf, ctl, sts, xr, spr, br;
  logic [15:0] tmr, rld;
  logic        s_port, s_tmr, s_shf, s_ctl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  data_space_map #(.RAM_BYTES(48)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .pins_l_i(pl), .pins_g_i(pg), .pins_i_i(pi),
    .port_l_dat_o(pld), .port_l_cfg_o(plc), .port_g_dat_o(pgd), .port_g_cfg_o(pgc),
    .port_d_dat_o(pdd), .shift_o(shf), .timer_o(tmr), .reload_o(rld),
    .ctrl_o(ctl), .status_o(sts), .x_o(xr), .sp_o(spr), .b_o(br),
    .sel_port_o(s_port), .sel_timer_o(s_tmr), .sel_shift_o(s_shf), .sel_ctrl_o(s_ctl)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_b(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rw_b(input logic [7:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic sel_at(input logic [7:0] a, input logic r, input logic [3:0] e, input string tag);
    @(negedge clk); addr = a; rd = r;
    #1 chk(tag, {12'd0, s_port, s_tmr, s_shf, s_ctl}, {12'd0, e});
    rd = 1'b0;
  endtask

  // monitor: pops expected read data one edge after each read strobe
  always @(posedge clk) begin
    if (rd) begin
      #(CLK_P/4);
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: unexpected read data %h", rdata);
      end else begin
        chk(tag_q.pop_front(), {8'd0, rdata}, {8'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 port L data", {8'd0, pld}, 16'h0);
    chk("R1 port D data", {8'd0, pdd}, 16'h0);
    chk("R1 timer", tmr, 16'h0);
    chk("R1 ctrl/status", {ctl, sts}, 16'h0);
    chk("R1 rdata", {8'd0, rdata}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_b(8'hD0, 8'h00, "R1 read port L after reset");

    // R2 RAM
    wr_b(8'h00, 8'h11); wr_b(8'h2F, 8'h22); wr_b(8'h15, 8'h5A);
    rd_b(8'h00, 8'h11, "R2 ram 0x00");
    rd_b(8'h2F, 8'h22, "R2 ram top");
    rd_b(8'h15, 8'h5A, "R2 ram mid");

    // R3 gap
    rd_b(8'h30, 8'hFF, "R3 gap start");
    rd_b(8'h7F, 8'hFF, "R3 gap end");
    wr_b(8'h40, 8'hEE); wr_b(8'h30, 8'h00);
    rd_b(8'h30, 8'hFF, "R3 gap after write");
    rd_b(8'h00, 8'h11, "R3 gap write no alias");

    // R4 reserved
    rd_b(8'h80, 8'h00, "R4 0x80");
    rd_b(8'hC5, 8'h00, "R4 0xC5");
    wr_b(8'hD3, 8'h77);
    rd_b(8'hD3, 8'h00, "R4 0xD3");
    rd_b(8'hE0, 8'h00, "R4 0xE0");

    // R6 ports
    wr_b(8'hD0, 8'h12); wr_b(8'hD1, 8'h34); wr_b(8'hD4, 8'h56);
    wr_b(8'hD5, 8'h78); wr_b(8'hDC, 8'h9A);
    chk("R6 port L", {pld, plc}, 16'h1234);
    chk("R6 port G", {pgd, pgc}, 16'h5678);
    chk("R6 port D", {8'd0, pdd}, 16'h009A);
    rd_b(8'hD5, 8'h78, "R6 read G cfg");

    // R7 pins
    rd_b(8'hD2, 8'hA5, "R7 pins L");
    rd_b(8'hD6, 8'h3C, "R7 pins G");
    rd_b(8'hD7, 8'h96, "R7 pins I");
    wr_b(8'hD2, 8'hFF); wr_b(8'hD6, 8'hFF); wr_b(8'hD7, 8'hFF);
    chk("R7 pin write ignored L", {pld, plc}, 16'h1234);
    chk("R7 pin write ignored G/D", {pgd, pdd}, 16'h569A);
    rd_b(8'hD2, 8'hA5, "R7 pins L after write");

    // R8 peripherals
    wr_b(8'hE9, 8'h01); wr_b(8'hEA, 8'h02); wr_b(8'hEB, 8'h03);
    wr_b(8'hEC, 8'h04); wr_b(8'hED, 8'h05); wr_b(8'hEE, 8'h06); wr_b(8'hEF, 8'h07);
    chk("R8 shift", {8'd0, shf}, 16'h0001);
    chk("R8 timer", tmr, 16'h0302);
    chk("R8 reload", rld, 16'h0504);
    chk("R8 ctrl/status", {ctl, sts}, 16'h0607);
    rd_b(8'hEB, 8'h03, "R8 read timer hi");

    // R9 register bank
    wr_b(8'hF0, 8'h0F); wr_b(8'hFC, 8'hC1); wr_b(8'hFD, 8'hD2);
    wr_b(8'hFE, 8'hE3); wr_b(8'hFF, 8'hF4);
    chk("R9 x/sp", {xr, spr}, 16'hC1D2);
    chk("R9 b", {8'd0, br}, 16'h00E3);
    rd_b(8'hF0, 8'h0F, "R9 bank F0");
    rd_b(8'hFF, 8'hF4, "R9 bank FF");

    // R5 back-to-back reads, then hold
    @(negedge clk); addr = 8'h2F; rd = 1'b1;
    exp_q.push_back(8'h22); tag_q.push_back("R5 b2b first");
    @(negedge clk); addr = 8'hFD;
    exp_q.push_back(8'hD2); tag_q.push_back("R5 b2b second");
    @(negedge clk); rd = 1'b0; addr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R5 hold while idle", {8'd0, rdata}, 16'h00D2);

    // R10 strobes
    sel_at(8'hD0, 1'b1, 4'b1000, "R10 port");
    sel_at(8'hEA, 1'b1, 4'b0100, "R10 timer");
    sel_at(8'hE9, 1'b1, 4'b0010, "R10 shift");
    sel_at(8'hEF, 1'b1, 4'b0001, "R10 ctrl");
    sel_at(8'h10, 1'b1, 4'b0000, "R10 ram no strobe");
    sel_at(8'hD0, 1'b0, 4'b0000, "R10 idle");

    // R11 same-cycle read/write
    rw_b(8'h15, 8'h77, 8'h5A, "R11 old value");
    rd_b(8'h15, 8'h77, "R11 new value");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R5: %0d reads without data, expected 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule